// File: doc/BRIEF.md
# Dual-Profile Clock Post-Divider and Output Selector

This block produces two output clocks from a reference clock and a clock coming out of a phase-locked loop. Both incoming clocks are level signals generated in, and sampled by, a fast sampling clock `clk`. Every output is a registered level in that same domain. An even post-divider divides by twice a programmable value `P`. It produces either the PLL clock or the reference clock divided by `2*P`, and a fixed divide-by-two stage serves the secondary output.

Two configuration profiles are stored side by side. Each profile holds a divider value, a primary source code and a secondary source code. The `prof_sel` input picks a profile while the block runs, so the output frequency can be switched on the fly. A global two-bit setting gives the multi-function pin one of three roles:
- an output-enable input;
- an active-low power-down input;
- the route for a second clock output.

Switching profile and enabling or disabling an output only take effect while the affected source is low. This keeps runt pulses off the outputs. Power-down is abrupt: it clears every divider and holds both outputs low.

Top module: `clkdiv_sel`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, both clock outputs are low and profile A (the one used when `prof_sel` is 1) is the active profile.
- R2: With primary source code 0, `clk0_out` toggles on every `P`-th rising edge of `pll_in`. Its period is therefore `2*P` PLL periods, with a 50% duty cycle.
- R3: A divider value of 0 behaves exactly like a value of 1, which gives divide-by-2.
- R4: The primary source code selects the source: 0 is PLL divided by `2*P`, 1 is the raw reference, 2 is the reference divided by `2*P`, and 3 behaves like 0. `clk0_out` follows the selected source one `clk` cycle later.
- R5: The secondary source code selects the source: 0 is the raw reference, 1 is the reference divided by 2, 2 is the primary source, and 3 is the primary source divided by 2. `clk1_out` carries a clock only in pin mode 2 and stays low in every other mode.
- R6: `pin_mode` encoding: 0 is output enable, 1 is power-down, 2 is secondary clock output, and 3 behaves like 0.
- R7: In output-enable mode, `pin_in` = 0 holds `clk0_out` low and 1 lets it run. The change is applied only at a cycle where the primary source is low.
- R8: In power-down mode with `pin_in` = 0, `pd_active` is high. Both outputs go low on the next cycle, and all dividers restart from count zero when `pin_in` returns to 1.
- R9: `prof_sel` = 1 selects profile A and 0 selects profile B. The new profile is adopted only at a cycle where the primary source is low and, in pin mode 2, the secondary source is also low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for all logic |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_in | input | 1 | Reference clock level |
| pll_in | input | 1 | PLL output clock level |
| prof_sel | input | 1 | Profile select, 1 = A, 0 = B |
| pin_in | input | 1 | Multi-function pin input level |
| pin_mode | input | 2 | Multi-function pin role |
| pa_div | input | P_W | Profile A divider value P |
| pa_src0 | input | 2 | Profile A primary source code |
| pa_src1 | input | 2 | Profile A secondary source code |
| pb_div | input | P_W | Profile B divider value P |
| pb_src0 | input | 2 | Profile B primary source code |
| pb_src1 | input | 2 | Profile B secondary source code |
| clk0_out | output | 1 | Primary clock output |
| clk1_out | output | 1 | Secondary clock output |
| pd_active | output | 1 | High while power-down is requested |

## Verification
The PLL level toggles every cycle and the reference level every three cycles. With these two unequal rates, a mix-up between the PLL and reference paths changes the output period. Divider values of 3 and 0, counted as output rising edges over a fixed window, tell a correct `2*P` divide apart from an off-by-one divide and from a zero divide. Every primary and secondary source code is stepped through, so each mux leg is compared against a behavioural model on every cycle. Profile switching, gated enable, power-down and the alternate output-enable code are driven mid-run, which shows whether changes wait for a low source phase and whether the dividers restart cleanly.

// File: rtl/clkdiv_sel_pkg.sv
package clkdiv_sel_pkg;
   typedef enum logic [1:0] {
      PIN_OE     = 2'd0,
      PIN_PDN    = 2'd1,
      PIN_CLK    = 2'd2,
      PIN_OE_ALT = 2'd3
   } pin_mode_e;

   typedef enum logic [1:0] {
      S0_PLL_DIV = 2'd0,
      S0_REF_RAW = 2'd1,
      S0_REF_DIV = 2'd2,
      S0_PLL_ALT = 2'd3
   } src0_e;

   typedef enum logic [1:0] {
      S1_REF_RAW  = 2'd0,
      S1_REF_HALF = 2'd1,
      S1_PRI      = 2'd2,
      S1_PRI_HALF = 2'd3
   } src1_e;

   localparam int SRC_W = 2;
endpackage

// File: rtl/clkdiv_sel_edge_div.sv
module clkdiv_sel_edge_div #(
   parameter int P_W = 5
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           clr,
   input  logic           src_in,
   input  logic [P_W-1:0] lim,
   output logic           samp,
   output logic           div_out
);
   logic [P_W-1:0] cnt;
   logic           rise;

   assign rise = src_in & ~samp;

   always_ff @(posedge clk) begin
      if (!rst_n) samp <= 1'b0;
      else        samp <= src_in;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         cnt     <= '0;
         div_out <= 1'b0;
      end else if (rise) begin
         if (cnt >= lim) begin
            cnt     <= '0;
            div_out <= ~div_out;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/clkdiv_sel_gate.sv
module clkdiv_sel_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic src,
   input  logic enable,
   output logic out
);
   logic en_q;

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         en_q <= 1'b0;
         out  <= 1'b0;
      end else begin
         out <= src & en_q;
         if (!src) en_q <= enable;
      end
   end
endmodule

// File: rtl/clkdiv_sel_prof.sv
module clkdiv_sel_prof
   import clkdiv_sel_pkg::*;
#(
   parameter int P_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             prof_sel,
   input  logic             idle,
   input  logic [P_W-1:0]   pa_div,
   input  logic [SRC_W-1:0] pa_src0,
   input  logic [SRC_W-1:0] pa_src1,
   input  logic [P_W-1:0]   pb_div,
   input  logic [SRC_W-1:0] pb_src0,
   input  logic [SRC_W-1:0] pb_src1,
   output logic [P_W-1:0]   lim,
   output logic [SRC_W-1:0] src0,
   output logic [SRC_W-1:0] src1
);
   logic           use_a;
   logic [P_W-1:0] p_raw;

   always_ff @(posedge clk) begin
      if (!rst_n)    use_a <= 1'b1;
      else if (idle) use_a <= prof_sel;
   end

   always_comb begin
      p_raw = use_a ? pa_div  : pb_div;
      src0  = use_a ? pa_src0 : pb_src0;
      src1  = use_a ? pa_src1 : pb_src1;
      lim   = (p_raw == '0) ? '0 : p_raw - 1'b1;
   end
endmodule

// File: rtl/clkdiv_sel.sv
module clkdiv_sel
   import clkdiv_sel_pkg::*;
#(
   parameter int P_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ref_in,
   input  logic             pll_in,
   input  logic             prof_sel,
   input  logic             pin_in,
   input  logic [1:0]       pin_mode,
   input  logic [P_W-1:0]   pa_div,
   input  logic [SRC_W-1:0] pa_src0,
   input  logic [SRC_W-1:0] pa_src1,
   input  logic [P_W-1:0]   pb_div,
   input  logic [SRC_W-1:0] pb_src0,
   input  logic [SRC_W-1:0] pb_src1,
   output logic             clk0_out,
   output logic             clk1_out,
   output logic             pd_active
);
   localparam int NDIV   = 4;
   localparam int D_PLL  = 0;
   localparam int D_REF  = 1;
   localparam int D_REFH = 2;
   localparam int D_PRIH = 3;

   generate
      if (P_W < 1 || P_W > 16) begin : g_bad_pw
         $error("clkdiv_sel: P_W must lie in 1..16");
      end
   endgenerate

   logic [P_W-1:0]   act_lim;
   logic [SRC_W-1:0] act_src0, act_src1;
   logic [NDIV-1:0]  d_src, d_samp, d_out;
   logic [P_W-1:0]   d_lim [NDIV];
   logic             c0_src, c1_src, want0, want1, idle, pd;
   pin_mode_e        mode;

   assign mode      = pin_mode_e'(pin_mode);
   assign pd        = (mode == PIN_PDN) && !pin_in;
   assign pd_active = pd;

   always_comb begin
      case (src0_e'(act_src0))
         S0_REF_RAW: c0_src = d_samp[D_REF];
         S0_REF_DIV: c0_src = d_out[D_REF];
         default:    c0_src = d_out[D_PLL];
      endcase
      case (src1_e'(act_src1))
         S1_REF_RAW:  c1_src = d_samp[D_REF];
         S1_REF_HALF: c1_src = d_out[D_REFH];
         S1_PRI:      c1_src = c0_src;
         default:     c1_src = d_out[D_PRIH];
      endcase
   end

   assign want0 = (mode == PIN_OE || mode == PIN_OE_ALT) ? pin_in : 1'b1;
   assign want1 = (mode == PIN_CLK);
   assign idle  = !c0_src && (!c1_src || mode != PIN_CLK);

   assign d_src = {c0_src, ref_in, ref_in, pll_in};

   clkdiv_sel_prof #(.P_W(P_W)) u_prof (
      .clk(clk), .rst_n(rst_n), .prof_sel(prof_sel), .idle(idle),
      .pa_div(pa_div), .pa_src0(pa_src0), .pa_src1(pa_src1),
      .pb_div(pb_div), .pb_src0(pb_src0), .pb_src1(pb_src1),
      .lim(act_lim), .src0(act_src0), .src1(act_src1)
   );

   genvar gi;
   generate
      for (gi = 0; gi < NDIV; gi++) begin : g_div
         if (gi == D_PLL || gi == D_REF) begin : g_prog
            assign d_lim[gi] = act_lim;
         end else begin : g_half
            assign d_lim[gi] = '0;
         end
         clkdiv_sel_edge_div #(.P_W(P_W)) u_div (
            .clk(clk), .rst_n(rst_n), .clr(pd), .src_in(d_src[gi]),
            .lim(d_lim[gi]), .samp(d_samp[gi]), .div_out(d_out[gi])
         );
      end
   endgenerate

   clkdiv_sel_gate u_gate0 (
      .clk(clk), .rst_n(rst_n), .clr(pd), .src(c0_src),
      .enable(want0), .out(clk0_out)
   );

   clkdiv_sel_gate u_gate1 (
      .clk(clk), .rst_n(rst_n), .clr(pd), .src(c1_src),
      .enable(want1), .out(clk1_out)
   );
endmodule

// File: rtl/clkdiv_sel_chk.sv
module clkdiv_sel_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       pin_in,
   input logic [1:0] pin_mode,
   input logic       clk0_out,
   input logic       clk1_out,
   input logic       pd_active
);
   logic oe_off;
   assign oe_off = (pin_mode == 2'd0 || pin_mode == 2'd3) && !pin_in;

   a_r8_pd_low: assert property (@(posedge clk) disable iff (!rst_n)
      pd_active |=> (!clk0_out && !clk1_out));

   a_r8_restart_low: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(pd_active) && !pd_active) |-> (!clk0_out && !clk1_out));

   a_r8_no_rise_in_pd: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(clk0_out) |-> !$past(pd_active));

   // R7: a disabled primary output that is already low stays low
   a_r7_oe_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (oe_off && $past(oe_off) && $past(oe_off, 2) && !$past(clk0_out)) |-> !clk0_out);
endmodule

bind clkdiv_sel clkdiv_sel_chk u_chk (
   .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .pin_mode(pin_mode),
   .clk0_out(clk0_out), .clk1_out(clk1_out), .pd_active(pd_active)
);

// File: tb/clkdiv_sel_bench.sv
module clkdiv_sel_bench;
   localparam int P_W = 5;

   logic clk = 1'b0, rst_n = 1'b0, ref_in = 1'b0, pll_in = 1'b0;
   logic prof_sel = 1'b1, pin_in = 1'b1;
   logic [1:0] pin_mode = 2'd2;
   logic [P_W-1:0] pa_div = 5'd3, pb_div = 5'd5;
   logic [1:0] pa_src0 = 2'd0, pa_src1 = 2'd3, pb_src0 = 2'd2, pb_src1 = 2'd1;
   logic clk0_out, clk1_out, pd_active;

   int errors = 0, checks = 0, tick_no = 0, rises = 0;
   logic prev0 = 1'b0;

   always #5 clk = ~clk;

   clkdiv_sel #(.P_W(P_W)) u_clkdiv_sel (
      .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .pll_in(pll_in),
      .prof_sel(prof_sel), .pin_in(pin_in), .pin_mode(pin_mode),
      .pa_div(pa_div), .pa_src0(pa_src0), .pa_src1(pa_src1),
      .pb_div(pb_div), .pb_src0(pb_src0), .pb_src1(pb_src1),
      .clk0_out(clk0_out), .clk1_out(clk1_out), .pd_active(pd_active)
   );

   // behavioural reference state
   int m_cnt_p = 0, m_cnt_r = 0;
   bit m_refq, m_pllq, m_dp, m_dr, m_hr, m_c0q, m_hc, m_en0, m_en1, m_o0, m_o1;
   bit m_a = 1'b1;

   task automatic model_step();
      int peff;
      bit c0, c1, pd, w0, w1;
      if (!rst_n) begin
         m_cnt_p = 0; m_cnt_r = 0;
         {m_refq, m_pllq, m_dp, m_dr, m_hr, m_c0q, m_hc, m_en0, m_en1, m_o0, m_o1} = '0;
         m_a = 1'b1;
         return;
      end
      peff = m_a ? int'(pa_div) : int'(pb_div);
      if (peff == 0) peff = 1;
      case (m_a ? pa_src0 : pb_src0)
         2'd1: c0 = m_refq;
         2'd2: c0 = m_dr;
         default: c0 = m_dp;
      endcase
      case (m_a ? pa_src1 : pb_src1)
         2'd0: c1 = m_refq;
         2'd1: c1 = m_hr;
         2'd2: c1 = c0;
         default: c1 = m_hc;
      endcase
      pd = (pin_mode == 2'd1) && !pin_in;
      w0 = (pin_mode == 2'd0 || pin_mode == 2'd3) ? pin_in : 1'b1;
      w1 = (pin_mode == 2'd2);
      if (!c0 && (!c1 || pin_mode != 2'd2)) m_a = prof_sel;
      if (pd) begin
         m_cnt_p = 0; m_cnt_r = 0;
         {m_dp, m_dr, m_hr, m_hc, m_en0, m_en1, m_o0, m_o1} = '0;
      end else begin
         if (pll_in && !m_pllq) begin
            if (m_cnt_p >= peff - 1) begin m_cnt_p = 0; m_dp = !m_dp; end
            else m_cnt_p++;
         end
         if (ref_in && !m_refq) begin
            if (m_cnt_r >= peff - 1) begin m_cnt_r = 0; m_dr = !m_dr; end
            else m_cnt_r++;
            m_hr = !m_hr;
         end
         if (c0 && !m_c0q) m_hc = !m_hc;
         m_o0 = c0 && m_en0;
         if (!c0) m_en0 = w0;
         m_o1 = c1 && m_en1;
         if (!c1) m_en1 = w1;
      end
      m_pllq = pll_in;
      m_refq = ref_in;
      m_c0q  = c0;
   endtask

   always @(posedge clk) model_step();

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d (tick %0d)", req, act, exp, tick_no);
      end
   endtask

   // one sample cycle: compare at the falling edge, then advance the input clocks
   task automatic tick();
      @(negedge clk);
      tick_no++;
      check(clk0_out === m_o0, "R4 clk0_out", int'(clk0_out), int'(m_o0));
      check(clk1_out === m_o1, "R5 clk1_out", int'(clk1_out), int'(m_o1));
      check(pd_active === ((pin_mode == 2'd1) && !pin_in), "R8 pd_active",
            int'(pd_active), int'((pin_mode == 2'd1) && !pin_in));
      if (clk0_out && !prev0) rises++;
      prev0 = clk0_out;
      pll_in = ~pll_in;
      if (tick_no % 3 == 0) ref_in = ~ref_in;
   endtask

   task automatic run(input int n);
      for (int i = 0; i < n; i++) tick();
   endtask

   task automatic count_rises(input int n, input int exp, input string req);
      rises = 0;
      run(n);
      check(rises >= exp - 1 && rises <= exp + 1, req, rises, exp);
   endtask

   initial begin
      #200000;
      errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      // R1: reset state
      run(4);
      check(clk0_out === 1'b0 && clk1_out === 1'b0, "R1 outputs low in reset",
            int'({clk0_out, clk1_out}), 0);
      rst_n = 1'b1;
      tick();
      check(clk0_out === 1'b0 && clk1_out === 1'b0, "R1 outputs low after reset",
            int'({clk0_out, clk1_out}), 0);
      run(20);
      // R2: P=3 on PLL, period 12 ticks -> 10 rises in 120
      count_rises(120, 10, "R2 divide by 2*P");
      // R3: P=0 behaves as 1 -> period 4 ticks -> 30 rises
      pa_div = 5'd0;
      run(10);
      count_rises(120, 30, "R3 zero divider as one");
      pa_div = 5'd1;
      count_rises(120, 30, "R3 divider one");
      // R4 / R5: walk all source codes
      pa_div = 5'd2;
      for (int s0 = 0; s0 < 4; s0++) begin
         for (int s1 = 0; s1 < 4; s1++) begin
            pa_src0 = 2'(s0);
            pa_src1 = 2'(s1);
            run(40);
         end
      end
      // R9: switch to profile B (ref/2P with P=5 -> period 60 ticks)
      prof_sel = 1'b0;
      run(30);
      count_rises(240, 4, "R9 profile B rate");
      prof_sel = 1'b1;
      pa_src0 = 2'd0; pa_src1 = 2'd3; pa_div = 5'd3;
      run(60);
      // R7: output enable off then on
      pin_mode = 2'd0;
      run(20);
      check(clk1_out === 1'b0, "R5 clk1 absent outside clock mode", int'(clk1_out), 0);
      pin_in = 1'b0;
      run(20);
      count_rises(60, 0, "R7 disabled output silent");
      pin_in = 1'b1;
      count_rises(120, 10, "R7 re-enabled output");
      // R6: code 3 acts as output enable
      pin_mode = 2'd3;
      pin_in = 1'b0;
      run(20);
      count_rises(60, 0, "R6 alternate enable code");
      pin_in = 1'b1;
      run(20);
      // R8: power-down
      pin_mode = 2'd1;
      pin_in = 1'b0;
      tick();
      check(pd_active === 1'b1, "R8 flag raised", int'(pd_active), 1);
      run(2);
      check(clk0_out === 1'b0 && clk1_out === 1'b0, "R8 outputs held low",
            int'({clk0_out, clk1_out}), 0);
      count_rises(40, 0, "R8 no edges in power-down");
      pin_in = 1'b1;
      count_rises(120, 10, "R8 restart rate");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule